// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block governs the collection window during which a host may keep adding sectors to a pending erase. The first sector erase command opens the window and marks its sector in a selection mask. Every later sector command that arrives while the window is open adds its sector and restarts the full window. When a whole window passes with no new command, the block raises the erase-timer status bit, emits a one-cycle start pulse with the gathered mask, and ignores all commands until an erase-done indication returns it to idle.

A whole-chip erase command does not go through the window. It moves the block to a busy state in which the timer status bit stays low, no start pulse is issued and sector commands are ignored until the erase completes. The window length is a cycle-count parameter. At 250 MHz a 50 µs window is 12500 cycles, which is the default.

Top module: `sect_erase_window`

## Requirements
- R1: After reset the mask is all zero, and `timer_bit` and `start_pulse` are low.
- R2: A sector command accepted in idle sets mask bit `sect_idx` (bit i stands for sector i) in the next cycle, while `timer_bit` stays 0.
- R3: `timer_bit` and `start_pulse` are first seen high exactly WINDOW_CYCLES clock cycles after the clock edge that sampled the last accepted sector command, and `timer_bit` stays 0 until then.
- R4: A sector command for a new sector while the window is open ORs its bit into the mask and restarts the full window.
- R5: A sector command that repeats an already selected sector restarts the full window and leaves the mask unchanged.
- R6: `start_pulse` is high for exactly one cycle, and the mask holds the whole accumulated set while it is high.
- R7: While `timer_bit` is 1, sector and chip commands change neither the mask nor `timer_bit`.
- R8: `erase_done` while `timer_bit` is 1 clears the mask and `timer_bit` in the next cycle, and a later sector command is accepted again.
- R9: A chip command in idle takes priority over a sector command in the same cycle. It enters a chip-busy state that never raises `timer_bit` or `start_pulse` and ignores sector commands until `erase_done`.
- R10: A chip command while the window is open is ignored and does not move the expiry time.
- R11: `erase_done` in idle or while the window is open has no effect.
- R12: Reset from any state returns the block to idle with an empty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sect_cmd | input | 1 | Sector erase command strobe |
| sect_idx | input | IW | Sector number for `sect_cmd` |
| chip_cmd | input | 1 | Whole-chip erase command strobe |
| erase_done | input | 1 | Internal erase finished |
| sect_mask | output | NUM_SECTORS | Selected sectors, bit i = sector i |
| timer_bit | output | 1 | Erase-timer status: 0 = window open or idle, 1 = erase started |
| start_pulse | output | 1 | One-cycle start of the internal sector erase |

## Verification
The bench uses a 4-sector, 6-cycle window and sweeps every ordered pair of sectors at every gap that keeps the window open. For each run it measures the distance from the second command to expiry and checks the OR of the two sector bits. Distinct pairs separate mask accumulation from restart. Equal pairs show that a repeat restarts the window without changing the mask. Gap variation shows that the window is counted from the latest command and not from the first. Separate sequences cover ignored commands and `erase_done` in each state, chip-erase priority, and reset taken in the middle of each phase.

// File: rtl/sew_pkg.sv
package sew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_ERASE = 2'd2,
    ST_CHIP  = 2'd3
  } sew_state_e;

  // Width of a counter that must hold values 0..limit.
  function automatic int count_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Width of an index that addresses n items.
  function automatic int index_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sew_window_timer.sv
module sew_window_timer #(
  parameter int WINDOW_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);
  import sew_pkg::*;
  localparam int CW = count_width(WINDOW_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // Expiry is the edge at which the final idle cycle of the window completes.
  assign expire = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= '0;
    else if (run && !expire) cnt_q <= cnt_q + 1'b1;
    else if (!run)           cnt_q <= '0;
  end
endmodule

// File: rtl/sew_mask_acc.sv
module sew_mask_acc #(
  parameter int NUM_SECTORS = 8,
  parameter int IW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   add,
  input  logic [IW-1:0]          idx,
  output logic [NUM_SECTORS-1:0] mask
);
  function automatic logic [NUM_SECTORS-1:0] sector_bit(input logic [IW-1:0] i);
    logic [NUM_SECTORS-1:0] v;
    v = '0;
    for (int k = 0; k < NUM_SECTORS; k++)
      if (i == IW'(k)) v[k] = 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask <= '0;
    else if (clear) mask <= '0;
    else if (add)   mask <= mask | sector_bit(idx);
  end
endmodule

// File: rtl/sect_erase_window.sv
module sect_erase_window #(
  parameter int NUM_SECTORS   = 8,
  parameter int WINDOW_CYCLES = 12500,
  parameter int IW            = sew_pkg::index_width(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sect_cmd,
  input  logic [IW-1:0]          sect_idx,
  input  logic                   chip_cmd,
  input  logic                   erase_done,
  output logic [NUM_SECTORS-1:0] sect_mask,
  output logic                   timer_bit,
  output logic                   start_pulse
);
  import sew_pkg::*;

  sew_state_e state_q, state_d;

  // Named internal events, brought out for the checker.
  logic accept_sect;
  logic accept_chip;
  logic window_expire;
  logic erase_finish;
  logic chip_busy;
  logic window_run;
  logic start_q;

  assign accept_chip  = (state_q == ST_IDLE) && chip_cmd;
  assign accept_sect  = sect_cmd &&
                        (((state_q == ST_IDLE) && !chip_cmd) || (state_q == ST_ACCUM));
  assign erase_finish = erase_done && ((state_q == ST_ERASE) || (state_q == ST_CHIP));
  assign chip_busy    = (state_q == ST_CHIP);
  assign window_run   = (state_q == ST_ACCUM);

  sew_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept_sect),
    .run     (window_run),
    .expire  (window_expire)
  );

  sew_mask_acc #(.NUM_SECTORS(NUM_SECTORS), .IW(IW)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (erase_finish),
    .add   (accept_sect),
    .idx   (sect_idx),
    .mask  (sect_mask)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_chip)      state_d = ST_CHIP;
        else if (accept_sect) state_d = ST_ACCUM;
      end
      ST_ACCUM: if (window_expire) state_d = ST_ERASE;
      ST_ERASE: if (erase_finish)  state_d = ST_IDLE;
      ST_CHIP:  if (erase_finish)  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= window_expire;
    end
  end

  assign timer_bit   = (state_q == ST_ERASE);
  assign start_pulse = start_q;
endmodule

// File: rtl/sew_chk.sv
module sew_chk #(
  parameter int NUM_SECTORS   = 8,
  parameter int WINDOW_CYCLES = 12500,
  parameter int IW            = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sect_cmd,
  input logic [IW-1:0]          sect_idx,
  input logic                   chip_cmd,
  input logic                   erase_done,
  input logic [NUM_SECTORS-1:0] sect_mask,
  input logic                   timer_bit,
  input logic                   start_pulse,
  input logic                   accept_sect,
  input logic                   chip_busy,
  input logic                   window_expire
);
  localparam int SW = sew_pkg::count_width(WINDOW_CYCLES + 1);
  localparam logic [SW-1:0] CAP = SW'(WINDOW_CYCLES + 1);
  localparam logic [SW-1:0] WIN = SW'(WINDOW_CYCLES);

  // Cycles since the last accepted sector command, saturating.
  logic [SW-1:0] since_cmd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_cmd <= CAP;
    else if (accept_sect)     since_cmd <= '0;
    else if (since_cmd < CAP) since_cmd <= since_cmd + 1'b1;
  end

  // R3
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_bit) |-> (since_cmd == WIN));

  // R3
  rise_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_bit) |-> start_pulse);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R6
  expire_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window_expire |=> (start_pulse && timer_bit));

  // R2
  mask_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_sect |=> sect_mask[$past(sect_idx)]);

  // R7
  locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_bit && !erase_done && (sect_cmd || chip_cmd)) |=> (timer_bit && $stable(sect_mask)));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_bit && erase_done) |=> (!timer_bit && (sect_mask == '0)));

  // R9
  chip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_busy |-> (!timer_bit && !start_pulse && (sect_mask == '0)));
endmodule

bind sect_erase_window sew_chk #(
  .NUM_SECTORS(NUM_SECTORS), .WINDOW_CYCLES(WINDOW_CYCLES), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sect_cmd(sect_cmd), .sect_idx(sect_idx),
  .chip_cmd(chip_cmd), .erase_done(erase_done), .sect_mask(sect_mask),
  .timer_bit(timer_bit), .start_pulse(start_pulse), .accept_sect(accept_sect),
  .chip_busy(chip_busy), .window_expire(window_expire)
);

// File: tb/sim_sect_erase_window.sv
`timescale 1ns/1ps
module sim_sect_erase_window;
  localparam int N  = 4;
  localparam int W  = 6;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sect_cmd = 1'b0;
  logic [IW-1:0] sect_idx = '0;
  logic chip_cmd = 1'b0;
  logic erase_done = 1'b0;
  logic [N-1:0] sect_mask;
  logic timer_bit;
  logic start_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sect_erase_window #(.NUM_SECTORS(N), .WINDOW_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sect_cmd(sect_cmd), .sect_idx(sect_idx),
    .chip_cmd(chip_cmd), .erase_done(erase_done), .sect_mask(sect_mask),
    .timer_bit(timer_bit), .start_pulse(start_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Each stimulus task starts and ends at a falling edge.
  task automatic pulse(input bit s, input int idx, input bit c, input bit d);
    sect_cmd = s; sect_idx = IW'(idx); chip_cmd = c; erase_done = d;
    @(negedge clk);
    sect_cmd = 0; chip_cmd = 0; erase_done = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Cycles until timer_bit is seen; start_pulse must appear with it.
  task automatic wait_expire(output int n, output bit st);
    n = 0; st = 0;
    for (int i = 1; i <= 4 * W; i++) begin
      @(negedge clk);
      if (timer_bit) begin n = i; st = start_pulse; break; end
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    int n;
    bit st;
    logic [N-1:0] exp_m;
    do_reset();
    // R1
    chk(sect_mask == 0 && !timer_bit && !start_pulse, "R1 reset", int'(sect_mask), 0);

    // R2 R3: single command per sector
    for (int s = 0; s < N; s++) begin
      pulse(1, s, 0, 0);
      chk(sect_mask == N'(1 << s) && !timer_bit, "R2 first sector", int'(sect_mask), 1 << s);
      wait_expire(n, st);
      chk(n == W, "R3 window length", n, W);
      chk(st, "R3 start with status", int'(st), 1);
      pulse(0, 0, 0, 1);
      chk(sect_mask == 0 && !timer_bit, "R8 done clears", int'(sect_mask), 0);
    end

    // R4 R5 R6 R7 R8: every pair of sectors at every open gap
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        for (int g = 1; g < W; g++) begin
          exp_m = N'((1 << a) | (1 << b));
          pulse(1, a, 0, 0);
          idle(g - 1);
          pulse(1, b, 0, 0);
          wait_expire(n, st);
          chk(n == W, (a == b) ? "R5 repeat restarts" : "R4 add restarts", n, W);
          chk(sect_mask == exp_m, (a == b) ? "R5 mask unchanged" : "R4 mask or", int'(sect_mask), int'(exp_m));
          chk(st, "R6 pulse at expiry", int'(st), 1);
          @(negedge clk);
          chk(!start_pulse && timer_bit, "R6 one cycle", int'(start_pulse), 0);
          pulse(1, (a + 1) % N, 0, 0);
          pulse(0, 0, 1, 0);
          chk(sect_mask == exp_m && timer_bit, "R7 locked", int'(sect_mask), int'(exp_m));
          pulse(0, 0, 0, 1);
          chk(sect_mask == 0 && !timer_bit, "R8 done clears", int'(sect_mask), 0);
        end

    // R9: chip wins over a same-cycle sector command, never raises status
    pulse(1, 2, 1, 0);
    chk(sect_mask == 0 && !timer_bit, "R9 chip priority", int'(sect_mask), 0);
    st = 0;
    for (int i = 0; i < 2 * W; i++) begin
      @(negedge clk);
      if (timer_bit || start_pulse) st = 1;
    end
    chk(!st, "R9 no status in chip erase", int'(st), 0);
    pulse(1, 1, 0, 0);
    chk(sect_mask == 0, "R9 sector ignored in chip erase", int'(sect_mask), 0);
    pulse(0, 0, 0, 1);
    pulse(1, 1, 0, 0);
    chk(sect_mask == 4'b0010, "R9 accepted after done", int'(sect_mask), 2);
    wait_expire(n, st);
    chk(n == W, "R9 window after chip", n, W);
    pulse(0, 0, 0, 1);

    // R10: chip command inside window ignored, expiry unchanged
    pulse(1, 3, 0, 0);
    pulse(0, 0, 1, 0);
    wait_expire(n, st);
    chk(n == W - 1, "R10 chip ignored in window", n, W - 1);
    chk(sect_mask == 4'b1000, "R10 mask", int'(sect_mask), 8);
    pulse(0, 0, 0, 1);

    // R11: erase_done in idle and in window
    pulse(0, 0, 0, 1);
    chk(sect_mask == 0 && !timer_bit, "R11 done in idle", int'(sect_mask), 0);
    pulse(1, 0, 0, 0);
    pulse(0, 0, 0, 1);
    chk(sect_mask == 4'b0001, "R11 done in window keeps mask", int'(sect_mask), 1);
    wait_expire(n, st);
    chk(n == W - 1, "R11 done in window keeps timing", n, W - 1);
    pulse(0, 0, 0, 1);

    // R12: reset mid window, mid erase, mid chip erase
    pulse(1, 2, 0, 0);
    idle(2);
    do_reset();
    chk(sect_mask == 0 && !timer_bit, "R12 reset in window", int'(sect_mask), 0);
    idle(W + 2);
    chk(!timer_bit, "R12 no late expiry", int'(timer_bit), 0);
    pulse(1, 1, 0, 0);
    wait_expire(n, st);
    do_reset();
    chk(sect_mask == 0 && !timer_bit, "R12 reset in erase", int'(sect_mask), 0);
    pulse(0, 0, 1, 0);
    do_reset();
    pulse(1, 3, 0, 0);
    chk(sect_mask == 4'b1000, "R12 reset in chip erase", int'(sect_mask), 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule